// File: doc/BRIEF.md
# Multi-Function Integer Arithmetic Unit

This block is a purely combinational arithmetic stage for a 16-bit datapath. It takes two unsigned operands and a 3-bit operation code. It returns one of four results: a sum, a difference, the first operand plus one, or the full product of the two low operand bytes. It also returns a carry bit and a flag that says whether that carry bit means anything for the current code.

A surrounding datapath uses the flag to decide whether to take the carry into its condition state. There is no clock, no register and no reset inside the block. Every output follows its inputs within the same cycle.

Top module: `arith_unit`

## Requirements
- R1: With `op_sel` = 3'b000, `result` equals (`op_a` + `op_b`) mod 2^16 and `carry_out` equals bit 16 of the 17-bit unsigned sum.
- R2: With `op_sel` = 3'b001, `result` equals (`op_a` - `op_b`) mod 2^16 and `carry_out` is 1 exactly when no borrow occurs, that is when `op_a` >= `op_b` unsigned.
- R3: With `op_sel` = 3'b010, `result` equals (`op_a` + 1) mod 2^16, `op_b` has no effect, and `carry_out` is 1 only when `op_a` is 16'hFFFF.
- R4: With `op_sel` = 3'b011, `result` equals the unsigned 16-bit product `op_a[7:0]` * `op_b[7:0]`, and bits 15:8 of both operands have no effect.
- R5: With `op_sel` in 3'b100 to 3'b111, `result` is 16'h0000 and `carry_out` is 0 for any operands.
- R6: `carry_valid` is 1 for codes 3'b000 to 3'b011 and 0 for codes 3'b100 to 3'b111.
- R7: `carry_out` is 0 whenever the multiply code 3'b011 is selected or `carry_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand, unsigned |
| op_b | input | 16 | Second operand, unsigned |
| op_sel | input | 3 | Operation code |
| result | output | 16 | Selected arithmetic result |
| carry_out | output | 1 | Carry, or no-borrow for subtraction |
| carry_valid | output | 1 | High when the code is one of the four arithmetic codes |

## Verification
The bench builds the block with its default widths: 16-bit operands and an 8-bit multiplier lane. With these widths the product of the low bytes can fill every result bit, as 8'hFF times 8'hFF gives 16'hFE01, so the product needs no padding. The carry chain can also wrap at 16'hFFFF under both addition and increment. Directed operands cover equal operands in subtraction, zero operands, and high operand bytes that the multiplier must ignore. Random operands then exercise all eight codes.

// File: rtl/arith_unit_pkg.sv
package arith_unit_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_MUL  = 3'b011,
    OP_RSV4 = 3'b100,
    OP_RSV5 = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } arith_op_e;

  typedef struct packed {
    logic use_adder;
    logic inv_b;
    logic zero_b;
    logic carry_in;
    logic use_mul;
    logic cy_valid;
  } arith_ctrl_t;

endpackage

// File: rtl/arith_op_decode.sv
module arith_op_decode
  import arith_unit_pkg::*;
(
  input  logic [2:0]  op_sel,
  output arith_ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (op_sel)
      OP_ADD: begin
        ctrl.use_adder = 1'b1;
        ctrl.cy_valid  = 1'b1;
      end
      OP_SUB: begin
        ctrl.use_adder = 1'b1;
        ctrl.inv_b     = 1'b1;
        ctrl.carry_in  = 1'b1;
        ctrl.cy_valid  = 1'b1;
      end
      OP_INC: begin
        ctrl.use_adder = 1'b1;
        ctrl.zero_b    = 1'b1;
        ctrl.carry_in  = 1'b1;
        ctrl.cy_valid  = 1'b1;
      end
      OP_MUL: begin
        ctrl.use_mul   = 1'b1;
        ctrl.cy_valid  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  // The two datapaths never drive the result together, and the carry flag
  // marks exactly the codes that select one of them.
  always_comb begin
    if (!$isunknown(op_sel)) begin
      assert_path_excl_R6: assert (!(ctrl.use_adder && ctrl.use_mul));
      assert_valid_codes_R6: assert (ctrl.cy_valid == (op_sel[2] == 1'b0));
    end
  end

endmodule

// File: rtl/arith_addsub.sv
module arith_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             inv_b,
  input  logic             zero_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic [EXT_W-1:0] total;

  always_comb begin
    if (zero_b)     b_eff = '0;
    else if (inv_b) b_eff = ~b;
    else            b_eff = b;
    total = EXT_W'(a) + EXT_W'(b_eff) + EXT_W'(carry_in);
  end

  assign sum  = total[WIDTH-1:0];
  assign cout = total[WIDTH];

  // Carry after an inverted-operand add with carry in is the no-borrow bit.
  always_comb begin
    if (!$isunknown({a, b, inv_b, zero_b, carry_in})) begin
      if (inv_b && !zero_b && carry_in)
        assert_no_borrow_R2: assert (cout == (a >= b));
      if (zero_b && carry_in)
        assert_inc_wrap_R3: assert (cout == (&a));
    end
  end

endmodule

// File: rtl/arith_mul.sv
module arith_mul #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  output logic [2*LANE_W-1:0] prod
);

  localparam int PROD_W = 2 * LANE_W;

  assign prod = PROD_W'(a) * PROD_W'(b);

  // A unit multiplier passes the other lane through unchanged.
  always_comb begin
    if (!$isunknown({a, b})) begin
      if (b == LANE_W'(1))
        assert_unit_factor_R4: assert (prod == PROD_W'(a));
    end
  end

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_unit_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int LANE_W = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             carry_valid
);

  localparam int PROD_W = 2 * LANE_W;

  arith_ctrl_t      ctrl;
  logic [WIDTH-1:0] sum;
  logic             add_cout;
  logic [PROD_W-1:0] prod;
  logic [WIDTH-1:0] prod_ext;

  arith_op_decode u_decode (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  arith_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a        (op_a),
    .b        (op_b),
    .inv_b    (ctrl.inv_b),
    .zero_b   (ctrl.zero_b),
    .carry_in (ctrl.carry_in),
    .sum      (sum),
    .cout     (add_cout)
  );

  arith_mul #(.LANE_W(LANE_W)) u_mul (
    .a    (op_a[LANE_W-1:0]),
    .b    (op_b[LANE_W-1:0]),
    .prod (prod)
  );

  generate
    if (PROD_W < WIDTH) begin : g_pad
      assign prod_ext = {{(WIDTH-PROD_W){1'b0}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    if (ctrl.use_adder)    result = sum;
    else if (ctrl.use_mul) result = prod_ext;
    else                   result = '0;
  end

  assign carry_out   = ctrl.use_adder & add_cout;
  assign carry_valid = ctrl.cy_valid;

  always_comb begin
    if (!$isunknown({op_a, op_b, op_sel})) begin
      if (op_sel[2])
        assert_reserved_zero_R5: assert (result == '0 && !carry_out);
      if (!carry_valid || op_sel == OP_MUL)
        assert_carry_gated_R7: assert (!carry_out);
    end
  end

endmodule

// File: tb/arith_unit_test.sv
module arith_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH  = 16;
  localparam int LANE_W = 8;

  logic clk;
  logic rst_n;
  logic [WIDTH-1:0] op_a, op_b, result;
  logic [2:0] op_sel;
  logic carry_out, carry_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [WIDTH-1:0] a, b;
    logic [2:0] op;
    logic [WIDTH-1:0] res;
    logic cy;
    logic vld;
  } exp_t;

  exp_t sb[$];

  arith_unit #(.WIDTH(WIDTH), .LANE_W(LANE_W)) uut (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(result), .carry_out(carry_out), .carry_valid(carry_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic exp_t model(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [2:0] op);
    exp_t e;
    logic [WIDTH:0] wide;
    e.a = a; e.b = b; e.op = op;
    e.res = '0; e.cy = 1'b0; e.vld = 1'b0;
    case (op)
      3'b000: begin wide = {1'b0, a} + {1'b0, b}; e.res = wide[WIDTH-1:0]; e.cy = wide[WIDTH]; e.vld = 1; end
      3'b001: begin e.res = a - b; e.cy = (a >= b); e.vld = 1; end
      3'b010: begin e.res = a + 1'b1; e.cy = (a == {WIDTH{1'b1}}); e.vld = 1; end
      3'b011: begin e.res = WIDTH'(int'(a[7:0]) * int'(b[7:0])); e.cy = 0; e.vld = 1; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic [2:0] op);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; op_sel = op;
    sb.push_back(model(a, b, op));
  endtask

  // Monitor: one expected item per cycle, compared at the falling edge.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h",
                 req_of(e.op), e.op, e.a, e.b, result, e.res);
      end
      checks++;
      if (carry_out !== e.cy) begin
        errors++;
        $display("FAIL %s/R7 carry op=%b a=%h b=%h actual=%b expected=%b",
                 req_of(e.op), e.op, e.a, e.b, carry_out, e.cy);
      end
      checks++;
      if (carry_valid !== e.vld) begin
        errors++;
        $display("FAIL R6 carry_valid op=%b actual=%b expected=%b", e.op, carry_valid, e.vld);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_sel = 3'b000;
    repeat (2) @(posedge clk);
    #2;
    // Idle state: zero operands with add selected gives zero, no carry.
    checks++;
    if (result !== '0 || carry_out !== 1'b0 || carry_valid !== 1'b1) begin
      errors++;
      $display("FAIL R1 idle actual=%h/%b/%b expected=0000/0/1", result, carry_out, carry_valid);
    end
    rst_n = 1'b1;

    // R1 add corners
    drive(16'hFFFF, 16'h0001, 3'b000);
    drive(16'h8000, 16'h8000, 3'b000);
    drive(16'h1234, 16'h4321, 3'b000);
    // R2 subtract corners
    drive(16'h0005, 16'h0005, 3'b001);
    drive(16'h0000, 16'h0001, 3'b001);
    drive(16'hFFFF, 16'h0000, 3'b001);
    // R3 increment wrap and ignored op_b
    drive(16'hFFFF, 16'h1234, 3'b010);
    drive(16'h7FFF, 16'hFFFF, 3'b010);
    // R4 multiply, high bytes ignored
    drive(16'h00FF, 16'h00FF, 3'b011);
    drive(16'hAB03, 16'hCD05, 3'b011);
    drive(16'hFFFF, 16'hFF00, 3'b011);
    // R5 reserved codes
    for (int k = 4; k < 8; k++) drive(16'hFFFF, 16'hFFFF, 3'(k));

    for (int i = 0; i < 400; i++)
      drive(WIDTH'($urandom), WIDTH'($urandom), 3'($urandom_range(0, 7)));

    wait (sb.size() == 0);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule